// File: doc/BRIEF.md
# Virtualization Intercept Decision Unit

This block decides, for each event reported by a running guest, whether that event has to be turned into a forced exit back to the hypervisor. The hypervisor hands over six intercept masks when it starts a guest: separate read and write masks for control registers, separate read and write masks for debug registers, a 32-bit exception mask and a 64-bit general intercept vector. Loading these masks also sets an intercepts-enabled flag. When the guest leaves, the general vector and the exception mask are cleared and the flag drops. The control-register and debug-register masks are kept.

Each event arrives as a valid strobe with an exit-type code and a 64-bit parameter. The code space is cut into fixed windows, and each window has its own base. Inside a window, the distance from the base selects one bit of that window's mask. A code that falls in no specific window and lies at or above the general base selects a bit of the general vector. When the selected bit is set and intercepts are enabled, the block raises a registered exit request for one cycle, carrying the event's code and parameter.

Top module: `vm_intercept_unit`

## Requirements
- R1: While the intercepts-enabled flag is clear, no exit request is raised for any event, whatever its code.
- R2: Codes from CRR_BASE (default 0x000) to CRR_BASE+8 raise an exit when bit (code − CRR_BASE) of the control-register read mask is set.
- R3: Codes from CRW_BASE (default 0x010) to CRW_BASE+8 raise an exit when bit (code − CRW_BASE) of the control-register write mask is set.
- R4: Codes from DRR_BASE (default 0x020) to DRR_BASE+7 raise an exit when bit (code − DRR_BASE) of the debug-register read mask is set.
- R5: Codes from DRW_BASE (default 0x030) to DRW_BASE+7 raise an exit when bit (code − DRW_BASE) of the debug-register write mask is set.
- R6: Codes from EXC_BASE (default 0x040) to EXC_BASE+31 raise an exit when bit (code − EXC_BASE) of the 32-bit exception mask is set.
- R7: A code in no specific window, with code ≥ GEN_BASE (default 0x060), raises an exit when bit (code − GEN_BASE) of the 64-bit general vector is set. If that offset is 64 or more, the code never raises an exit.
- R8: A code below GEN_BASE that lies in no window never raises an exit. This holds even when the matching bit position of a neighbouring mask is set (for example code 0x009 with bit 9 of the read mask set).
- R9: exit_req is high in exactly the cycle after a valid event whose selected bit is set. In that cycle exit_code and exit_param hold that event's code and parameter. With no valid event, exit_req is low in the following cycle.
- R10: A guest-entry strobe loads all six masks and sets the enable flag. These take effect for events in later cycles. An event in the same cycle as the strobe is judged against the previous state.
- R11: A guest-leave strobe clears the general vector and the exception mask and drops the enable flag. If entry and leave arrive in the same cycle, leave wins.
- R12: After reset, the enable flag is clear, all masks are zero and exit_req is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| guest_enter | input | 1 | Load all masks and enable intercepts |
| guest_leave | input | 1 | Clear general vector and exception mask, disable intercepts |
| ld_cr_rd | input | 16 | Control-register read mask to load |
| ld_cr_wr | input | 16 | Control-register write mask to load |
| ld_dr_rd | input | 16 | Debug-register read mask to load |
| ld_dr_wr | input | 16 | Debug-register write mask to load |
| ld_exc | input | 32 | Exception mask to load |
| ld_gen | input | 64 | General intercept vector to load |
| ev_valid | input | 1 | Event strobe |
| ev_code | input | 12 | Exit-type code of the event |
| ev_param | input | 64 | Event parameter |
| exit_req | output | 1 | One-cycle forced-exit request |
| exit_code | output | 12 | Code of the event that caused the exit |
| exit_param | output | 64 | Parameter of the event that caused the exit |

## Verification
Directed events probe the first and last code of every window, and a code whose mask bit is clear inside each window. Together these show that each window selects the right register and the right bit offset. Gap codes are driven with the matching bit of a neighbouring mask set, the first code past the 64-bit general range is driven, and events are sent in the same cycle as entry or leave strobes and while disabled. These cases separate window bounds from mask contents and show which state an event is judged against. A seeded random mix of codes across all windows and gaps, random masks and occasional entry and leave strobes is compared each cycle against a bench model. Back-to-back hits confirm that every exit echoes its own event's code and parameter.

// File: rtl/vmi_pkg.sv
package vmi_pkg;

  localparam int unsigned NWIN = 6;

  // Window slots; the general slot is the last one and yields to the others.
  typedef enum int unsigned {
    WIN_CRR = 0,
    WIN_CRW = 1,
    WIN_DRR = 2,
    WIN_DRW = 3,
    WIN_EXC = 4,
    WIN_GEN = 5
  } win_slot_e;

  // Specific windows always fire on their own bit; the general window
  // only counts when no specific window claimed the code.
  function automatic logic intercept_decide(input logic [NWIN-1:0] in_win,
                                            input logic [NWIN-1:0] bit_on);
    logic spec_claim;
    logic spec_fire;
    spec_claim = |in_win[NWIN-2:0];
    spec_fire  = |bit_on[NWIN-2:0];
    return spec_fire | (bit_on[NWIN-1] & ~spec_claim);
  endfunction

endpackage

// File: rtl/vmi_mask_bank.sv
module vmi_mask_bank #(
  parameter int unsigned CR_W  = 16,
  parameter int unsigned DR_W  = 16,
  parameter int unsigned EXC_W = 32,
  parameter int unsigned GEN_W = 64
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             enter,
  input  logic             leave,
  input  logic [CR_W-1:0]  in_cr_rd,
  input  logic [CR_W-1:0]  in_cr_wr,
  input  logic [DR_W-1:0]  in_dr_rd,
  input  logic [DR_W-1:0]  in_dr_wr,
  input  logic [EXC_W-1:0] in_exc,
  input  logic [GEN_W-1:0] in_gen,
  output logic [CR_W-1:0]  cr_rd_q,
  output logic [CR_W-1:0]  cr_wr_q,
  output logic [DR_W-1:0]  dr_rd_q,
  output logic [DR_W-1:0]  dr_wr_q,
  output logic [EXC_W-1:0] exc_q,
  output logic [GEN_W-1:0] gen_q,
  output logic             enabled_q
);

  // Register-access masks survive a leave; only entry rewrites them.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cr_rd_q <= '0;
      cr_wr_q <= '0;
      dr_rd_q <= '0;
      dr_wr_q <= '0;
    end else if (enter && !leave) begin
      cr_rd_q <= in_cr_rd;
      cr_wr_q <= in_cr_wr;
      dr_rd_q <= in_dr_rd;
      dr_wr_q <= in_dr_wr;
    end
  end

  // Exception mask, general vector and enable flag: leave has priority.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      exc_q     <= '0;
      gen_q     <= '0;
      enabled_q <= 1'b0;
    end else if (leave) begin
      exc_q     <= '0;
      gen_q     <= '0;
      enabled_q <= 1'b0;
    end else if (enter) begin
      exc_q     <= in_exc;
      gen_q     <= in_gen;
      enabled_q <= 1'b1;
    end
  end

endmodule

// File: rtl/vmi_window.sv
module vmi_window #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned BASE   = 0,
  parameter int unsigned SPAN   = 1,
  parameter int unsigned MW     = 64
) (
  input  logic [CODE_W-1:0] code,
  input  logic [MW-1:0]     mask,
  output logic              in_win,
  output logic              bit_on
);

  localparam int unsigned IW = (MW > 1) ? $clog2(MW) : 1;
  localparam logic [CODE_W:0] LO = (CODE_W+1)'(BASE);
  localparam logic [CODE_W:0] HI = (CODE_W+1)'(BASE + SPAN);

  logic [IW-1:0] off_idx;

  assign off_idx = IW'(code - CODE_W'(BASE));
  assign in_win  = ({1'b0, code} >= LO) && ({1'b0, code} < HI);
  assign bit_on  = in_win && mask[off_idx];

endmodule

// File: rtl/vmi_exit_stage.sv
module vmi_exit_stage #(
  parameter int unsigned CODE_W  = 12,
  parameter int unsigned PARAM_W = 64
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               fire,
  input  logic [CODE_W-1:0]  code,
  input  logic [PARAM_W-1:0] param,
  output logic               req_q,
  output logic [CODE_W-1:0]  code_q,
  output logic [PARAM_W-1:0] param_q
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      req_q   <= 1'b0;
      code_q  <= '0;
      param_q <= '0;
    end else begin
      req_q <= fire;
      if (fire) begin
        code_q  <= code;
        param_q <= param;
      end
    end
  end

endmodule

// File: rtl/vm_intercept_unit.sv
module vm_intercept_unit #(
  parameter int unsigned CODE_W   = 12,
  parameter int unsigned PARAM_W  = 64,
  parameter int unsigned CR_W     = 16,
  parameter int unsigned DR_W     = 16,
  parameter int unsigned EXC_W    = 32,
  parameter int unsigned GEN_W    = 64,
  parameter int unsigned CRR_BASE = 12'h000,
  parameter int unsigned CRW_BASE = 12'h010,
  parameter int unsigned DRR_BASE = 12'h020,
  parameter int unsigned DRW_BASE = 12'h030,
  parameter int unsigned EXC_BASE = 12'h040,
  parameter int unsigned GEN_BASE = 12'h060,
  parameter int unsigned CR_SPAN  = 9,
  parameter int unsigned DR_SPAN  = 8
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               guest_enter,
  input  logic               guest_leave,
  input  logic [CR_W-1:0]    ld_cr_rd,
  input  logic [CR_W-1:0]    ld_cr_wr,
  input  logic [DR_W-1:0]    ld_dr_rd,
  input  logic [DR_W-1:0]    ld_dr_wr,
  input  logic [EXC_W-1:0]   ld_exc,
  input  logic [GEN_W-1:0]   ld_gen,
  input  logic               ev_valid,
  input  logic [CODE_W-1:0]  ev_code,
  input  logic [PARAM_W-1:0] ev_param,
  output logic               exit_req,
  output logic [CODE_W-1:0]  exit_code,
  output logic [PARAM_W-1:0] exit_param
);
  import vmi_pkg::*;

  localparam int unsigned PAD_W = GEN_W;
  localparam int unsigned WIN_BASE [NWIN] =
    '{CRR_BASE, CRW_BASE, DRR_BASE, DRW_BASE, EXC_BASE, GEN_BASE};
  localparam int unsigned WIN_SPAN [NWIN] =
    '{CR_SPAN, CR_SPAN, DR_SPAN, DR_SPAN, EXC_W, GEN_W};

  // Named internal events, visible to the bound checker.
  logic [CR_W-1:0]  cr_rd_q, cr_wr_q;
  logic [DR_W-1:0]  dr_rd_q, dr_wr_q;
  logic [EXC_W-1:0] exc_mask_q;
  logic [GEN_W-1:0] gen_vec_q;
  logic             ints_enabled;
  logic [PAD_W-1:0] mask_arr [NWIN];
  logic [NWIN-1:0]  win_in;
  logic [NWIN-1:0]  win_hit;
  logic             fire;

  vmi_mask_bank #(
    .CR_W(CR_W), .DR_W(DR_W), .EXC_W(EXC_W), .GEN_W(GEN_W)
  ) u_bank (
    .clk(clk), .rst_n(rst_n),
    .enter(guest_enter), .leave(guest_leave),
    .in_cr_rd(ld_cr_rd), .in_cr_wr(ld_cr_wr),
    .in_dr_rd(ld_dr_rd), .in_dr_wr(ld_dr_wr),
    .in_exc(ld_exc), .in_gen(ld_gen),
    .cr_rd_q(cr_rd_q), .cr_wr_q(cr_wr_q),
    .dr_rd_q(dr_rd_q), .dr_wr_q(dr_wr_q),
    .exc_q(exc_mask_q), .gen_q(gen_vec_q),
    .enabled_q(ints_enabled)
  );

  always_comb begin
    mask_arr[WIN_CRR] = PAD_W'(cr_rd_q);
    mask_arr[WIN_CRW] = PAD_W'(cr_wr_q);
    mask_arr[WIN_DRR] = PAD_W'(dr_rd_q);
    mask_arr[WIN_DRW] = PAD_W'(dr_wr_q);
    mask_arr[WIN_EXC] = PAD_W'(exc_mask_q);
    mask_arr[WIN_GEN] = gen_vec_q;
  end

  for (genvar w = 0; w < NWIN; w++) begin : g_win
    vmi_window #(
      .CODE_W(CODE_W), .BASE(WIN_BASE[w]), .SPAN(WIN_SPAN[w]), .MW(PAD_W)
    ) u_win (
      .code(ev_code), .mask(mask_arr[w]),
      .in_win(win_in[w]), .bit_on(win_hit[w])
    );
  end

  assign fire = ev_valid && ints_enabled && intercept_decide(win_in, win_hit);

  vmi_exit_stage #(
    .CODE_W(CODE_W), .PARAM_W(PARAM_W)
  ) u_exit (
    .clk(clk), .rst_n(rst_n),
    .fire(fire), .code(ev_code), .param(ev_param),
    .req_q(exit_req), .code_q(exit_code), .param_q(exit_param)
  );

endmodule

// File: rtl/vmi_checker.sv
module vmi_checker #(
  parameter int unsigned CODE_W = 12,
  parameter int unsigned EXC_W  = 32,
  parameter int unsigned GEN_W  = 64,
  parameter int unsigned NW     = 6
) (
  input logic              clk,
  input logic              rst_n,
  input logic              guest_enter,
  input logic              guest_leave,
  input logic              ev_valid,
  input logic [CODE_W-1:0] ev_code,
  input logic              exit_req,
  input logic [CODE_W-1:0] exit_code,
  input logic              ints_enabled,
  input logic [NW-1:0]     win_in,
  input logic [EXC_W-1:0]  exc_mask_q,
  input logic [GEN_W-1:0]  gen_vec_q,
  input logic              fire
);

  AST_IDLE_WHEN_DISABLED: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && !ints_enabled) |=> !exit_req); // R1

  AST_WINDOWS_DISJOINT: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(win_in)); // R7

  AST_GAP_NO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    (ev_valid && win_in == '0) |=> !exit_req); // R8

  AST_NO_EVENT_NO_EXIT: assert property (@(posedge clk) disable iff (!rst_n)
    !ev_valid |=> !exit_req); // R9

  AST_EXIT_ECHO_CODE: assert property (@(posedge clk) disable iff (!rst_n)
    fire |=> (exit_req && exit_code == $past(ev_code))); // R9

  AST_ENTER_ENABLES: assert property (@(posedge clk) disable iff (!rst_n)
    (guest_enter && !guest_leave) |=> ints_enabled); // R10

  AST_LEAVE_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    guest_leave |=> (!ints_enabled && gen_vec_q == '0 && exc_mask_q == '0)); // R11

endmodule

bind vm_intercept_unit vmi_checker #(
  .CODE_W(CODE_W), .EXC_W(EXC_W), .GEN_W(GEN_W), .NW(vmi_pkg::NWIN)
) u_vmi_checker (
  .clk(clk), .rst_n(rst_n),
  .guest_enter(guest_enter), .guest_leave(guest_leave),
  .ev_valid(ev_valid), .ev_code(ev_code),
  .exit_req(exit_req), .exit_code(exit_code),
  .ints_enabled(ints_enabled), .win_in(win_in),
  .exc_mask_q(exc_mask_q), .gen_vec_q(gen_vec_q),
  .fire(fire)
);

// File: tb/tb_vm_intercept_unit.sv
module tb_vm_intercept_unit;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        guest_enter = 1'b0, guest_leave = 1'b0;
  logic [15:0] ld_cr_rd = '0, ld_cr_wr = '0, ld_dr_rd = '0, ld_dr_wr = '0;
  logic [31:0] ld_exc = '0;
  logic [63:0] ld_gen = '0;
  logic        ev_valid = 1'b0;
  logic [11:0] ev_code = '0;
  logic [63:0] ev_param = '0;
  logic        exit_req;
  logic [11:0] exit_code;
  logic [63:0] exit_param;

  int checks = 0;
  int errors = 0;

  // Bench model of the intercept state.
  bit        m_en = 0;
  bit [15:0] m_crr = 0, m_crw = 0, m_drr = 0, m_drw = 0;
  bit [31:0] m_exc = 0;
  bit [63:0] m_gen = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  vm_intercept_unit dut (
    .clk(clk), .rst_n(rst_n),
    .guest_enter(guest_enter), .guest_leave(guest_leave),
    .ld_cr_rd(ld_cr_rd), .ld_cr_wr(ld_cr_wr),
    .ld_dr_rd(ld_dr_rd), .ld_dr_wr(ld_dr_wr),
    .ld_exc(ld_exc), .ld_gen(ld_gen),
    .ev_valid(ev_valid), .ev_code(ev_code), .ev_param(ev_param),
    .exit_req(exit_req), .exit_code(exit_code), .exit_param(exit_param)
  );

  function automatic bit exp_hit(int c);
    if (!m_en) return 0;
    if (c inside {[0:8]})    return m_crr[c];
    if (c inside {[16:24]})  return m_crw[c-16];
    if (c inside {[32:39]})  return m_drr[c-32];
    if (c inside {[48:55]})  return m_drw[c-48];
    if (c inside {[64:95]})  return m_exc[c-64];
    if (c inside {[96:159]}) return m_gen[c-96];
    return 0;
  endfunction

  function automatic string tag_of(int c);
    if (c inside {[0:8]})    return "R2";
    if (c inside {[16:24]})  return "R3";
    if (c inside {[32:39]})  return "R4";
    if (c inside {[48:55]})  return "R5";
    if (c inside {[64:95]})  return "R6";
    if (c >= 96)             return "R7";
    return "R8";
  endfunction

  // Drive one cycle at the falling edge; check the registered result one cycle later.
  task automatic step(bit ent, bit lv, bit v, int c, logic [63:0] p, string tag);
    bit exp;
    guest_enter = ent; guest_leave = lv;
    ev_valid = v; ev_code = 12'(c); ev_param = p;
    exp = v && exp_hit(c);
    if (lv) begin
      m_en = 0; m_gen = 0; m_exc = 0;
    end else if (ent) begin
      m_en = 1; m_crr = ld_cr_rd; m_crw = ld_cr_wr; m_drr = ld_dr_rd;
      m_drw = ld_dr_wr; m_exc = ld_exc; m_gen = ld_gen;
    end
    @(negedge clk);
    guest_enter = 0; guest_leave = 0; ev_valid = 0;
    checks++;
    if (exit_req !== exp) begin
      errors++;
      $display("FAIL %s code=%0h exit_req actual=%0b expected=%0b", tag, c, exit_req, exp);
    end else if (exp && (exit_code !== 12'(c) || exit_param !== p)) begin
      errors++;
      $display("FAIL %s R9 echo actual=%0h/%0h expected=%0h/%0h",
               tag, exit_code, exit_param, c, p);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    void'($urandom(32'h5EED));
    repeat (3) @(negedge clk);
    checks++;
    if (exit_req !== 1'b0) begin
      errors++;
      $display("FAIL R12 reset exit_req actual=%0b expected=0", exit_req);
    end
    rst_n = 1'b1;
    @(negedge clk);
    step(0, 0, 1, 12'h060, 64'h1, "R12");   // reset masks zero, disabled
    // Event in same cycle as entry is judged against the disabled state.
    ld_cr_rd = 16'h0301; ld_cr_wr = 16'h0002; ld_dr_rd = 16'h0180; ld_dr_wr = 16'h0001;
    ld_exc = 32'h8000_0001; ld_gen = 64'h8000_0000_0000_0001;
    step(1, 0, 1, 12'h000, 64'h11, "R10");
    step(0, 0, 1, 12'h000, 64'hA5A5, "R2");
    step(0, 0, 1, 12'h008, 64'h2, "R2");
    step(0, 0, 1, 12'h001, 64'h3, "R2");
    step(0, 0, 1, 12'h009, 64'h4, "R8");     // bit 9 set but outside window
    step(0, 0, 1, 12'h011, 64'h5, "R3");
    step(0, 0, 1, 12'h010, 64'h6, "R3");
    step(0, 0, 1, 12'h027, 64'h7, "R4");
    step(0, 0, 1, 12'h028, 64'h8, "R8");     // bit 8 of DR read set, gap code
    step(0, 0, 1, 12'h030, 64'h9, "R5");
    step(0, 0, 1, 12'h037, 64'hA, "R5");
    step(0, 0, 1, 12'h040, 64'hB, "R6");
    step(0, 0, 1, 12'h05F, 64'hC, "R6");
    step(0, 0, 1, 12'h041, 64'hD, "R6");
    step(0, 0, 1, 12'h060, 64'hE, "R7");
    step(0, 0, 1, 12'h09F, 64'hF, "R7");
    step(0, 0, 1, 12'h0A0, 64'h10, "R7");    // offset 64: never
    step(0, 0, 1, 12'h061, 64'h11, "R7");
    step(0, 0, 1, 12'h000, 64'hDEAD, "R9");  // back-to-back hits
    step(0, 0, 1, 12'h040, 64'hBEEF, "R9");
    step(0, 0, 0, 12'h000, 64'h0, "R9");     // no event, no exit
    step(0, 1, 1, 12'h060, 64'h12, "R11");   // judged before leave: hit
    step(0, 0, 1, 12'h060, 64'h13, "R11");   // after leave: disabled
    step(0, 0, 1, 12'h000, 64'h14, "R1");
    step(1, 1, 0, 12'h000, 64'h0, "R11");    // leave wins over entry
    step(0, 0, 1, 12'h040, 64'h15, "R11");
    step(1, 0, 0, 12'h000, 64'h0, "R10");
    step(0, 0, 1, 12'h09F, 64'h16, "R10");
    // Seeded random mix.
    for (int i = 0; i < 4000; i++) begin
      bit e, l, v;
      int c;
      e = ($urandom_range(0, 15) == 0);
      l = ($urandom_range(0, 19) == 0);
      v = ($urandom_range(0, 3) != 0);
      c = $urandom_range(0, 175);
      if (e) begin
        ld_cr_rd = 16'($urandom); ld_cr_wr = 16'($urandom);
        ld_dr_rd = 16'($urandom); ld_dr_wr = 16'($urandom);
        ld_exc = $urandom; ld_gen = {$urandom, $urandom};
      end
      step(e, l, v, c, {$urandom, $urandom}, m_en ? tag_of(c) : "R1");
    end
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule